// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block runs single accesses to one asynchronous, non-multiplexed NOR Flash or SRAM part. An internal requester presents a read or write together with a word address, write data and three timing values. While the block is idle it takes the request and plays it out on the memory pins as a fixed sequence of phases, each counted in system clock cycles.

The first phase is address setup: chip select is low and both strobes are high. A setup length of zero leaves this phase out. The second is the data phase: output enable (read) or write enable (write) is low. The third is bus turnaround: every strobe is high before the next access may begin. A read captures the data bus in the last cycle of the data phase. A write drives the bus from the first cycle of the access to the last data cycle. A one-cycle done strobe marks the end of turnaround. A request that arrives while the block is busy has no effect. A request held high until the block is idle is taken in the same cycle as that done strobe.

The pins carry a 26-bit word address, so 64 Mi words of 16 bits are reachable. The data bus is split into an input, an output and an output enable, and an I/O cell outside the block joins them into one bidirectional bus.

Top module: `smem_async_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, mem_cs_n, mem_oe_n and mem_we_n are 1, and mem_dq_oe and done are 0.
- R2: An accepted access starts in the cycle after the accepting edge. The access holds mem_cs_n low with both strobes high for exactly cfg_addr_setup cycles (0 to 15). A value of 0 starts the data phase at once.
- R3: The data phase lasts cfg_data_setup + 1 cycles (1 to 256). During it, mem_oe_n is low for a read (req_we = 0) and mem_we_n is low for a write (req_we = 1). mem_cs_n stays low, and chip select and strobe rise together at its end.
- R4: After the data phase, cfg_turnaround cycles (0 to 15) follow with all strobes high. done is then 1 for exactly one cycle, with all strobes high, and is never raised without an access.
- R5: On a read, rd_data takes the value of mem_dq_i from the last cycle of the data phase and holds it until the next read capture.
- R6: On a write, mem_dq_oe is 1 and mem_dq_o equals the accepted write data in every cycle with mem_cs_n low. At all other times, and throughout a read, mem_dq_oe is 0.
- R7: mem_addr equals the accepted req_addr and stays unchanged in every cycle of the access.
- R8: A req pulse while an access is in progress starts no access. A req held high is accepted in the cycle in which done is 1, so mem_cs_n falls in the next cycle.
- R9: The address, write data, direction and all three timing values are taken at the accepting edge. Changes to them during the access have no effect on it.
- R10: mem_oe_n and mem_we_n are never low together, and neither is low while mem_cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, taken only when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Word address |
| req_wdata | input | 16 | Write data |
| cfg_addr_setup | input | 4 | Address setup cycles, 0 to 15 |
| cfg_data_setup | input | 8 | Data phase cycles minus one |
| cfg_turnaround | input | 4 | Turnaround cycles, 0 to 15 |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | One-cycle end-of-access strobe |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 26 | Memory word address |
| mem_dq_o | output | 16 | Data bus output value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data bus input value |

## Verification
Two events can fall in the same cycle: the done strobe of one access and the acceptance of the next request. The bench provokes this by raising the next request while the previous access is still running and holding it high with new address and timing values. It then checks that done is seen in the cycle just before chip select falls again, and that the new access uses the values present at that edge. The timing values cover zero setup, zero turnaround and the largest lengths. The memory model returns a word that changes in every data cycle, so that only a capture in the last cycle gives the expected value.

// File: rtl/smem_pkg.sv
// Shared definitions for the asynchronous static memory sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package smem_pkg;

    // Phase of the access in progress.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ASET = 2'd1,
        PH_DSET = 2'd2,
        PH_TURN = 2'd3
    } smem_phase_e;

    // Largest of three widths, used to size the shared phase counter.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/smem_phase_timer.sv
// Down-counter shared by all phases of an access.
// Loading a value N makes 'expired' true N cycles later; a load of 0 expires at once.
// Assumes: the sequencer loads it at every phase entry.
module smem_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count down toward zero, or reload at a phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/smem_sequencer.sv
// Phase state machine: idle -> address setup -> data -> turnaround -> idle.
// Takes a request only when idle, and skips address setup when its length is 0.
// The data length is stored minus one. Raises done for one cycle as turnaround ends.
// Assumes: the timer expires when its loaded count has elapsed.
module smem_sequencer
    import smem_pkg::*;
#(
    parameter int ASU_W  = 4,
    parameter int DSU_W  = 8,
    parameter int TURN_W = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ASU_W-1:0]  cfg_asu,
    input  logic [DSU_W-1:0]  cfg_dsu,
    input  logic [TURN_W-1:0] cfg_turn,
    input  logic              expired,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output smem_phase_e       phase,
    output logic              accept,
    output logic              capture,
    output logic              done
);

    smem_phase_e       phase_q, phase_d;
    logic [DSU_W-1:0]  dsu_q;
    logic [TURN_W-1:0] turn_q;
    logic              finish;

    // Work out the next phase and the counter load for each phase exit.
    always_comb begin
        phase_d  = phase_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        finish   = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    if (cfg_asu != '0) begin
                        phase_d  = PH_ASET;
                        load_val = CNT_W'(cfg_asu) - CNT_W'(1);
                    end else begin
                        phase_d  = PH_DSET;
                        load_val = CNT_W'(cfg_dsu);
                    end
                end
            end
            PH_ASET: begin
                if (expired) begin
                    phase_d  = PH_DSET;
                    load     = 1'b1;
                    load_val = CNT_W'(dsu_q);
                end
            end
            PH_DSET: begin
                if (expired) begin
                    capture = 1'b1;
                    if (turn_q != '0) begin
                        phase_d  = PH_TURN;
                        load     = 1'b1;
                        load_val = CNT_W'(turn_q) - CNT_W'(1);
                    end else begin
                        phase_d = PH_IDLE;
                        finish  = 1'b1;
                    end
                end
            end
            default: begin
                if (expired) begin
                    phase_d = PH_IDLE;
                    finish  = 1'b1;
                end
            end
        endcase
    end

    // Hold the phase, the latched lengths and the done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            dsu_q   <= '0;
            turn_q  <= '0;
            done    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done    <= finish;
            if (accept) begin
                dsu_q  <= cfg_dsu;
                turn_q <= cfg_turn;
            end
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/smem_pin_drive.sv
// Memory pin stage: latches address, data and direction when a request is taken.
// Decodes the active-low strobes and the bus drive enable from the phase.
// Captures read data on the last data cycle.
// Assumes: phase comes from a register, so the decoded strobes change only at edges.
module smem_pin_drive
    import smem_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  smem_phase_e       phase,
    input  logic              accept,
    input  logic              capture,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe
);

    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              in_access;
    logic              in_data;

    // Latch the request fields when the request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            we_q    <= req_we;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the data bus in the last cycle of a read data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (capture && !we_q) begin
            rd_data <= mem_dq_i;
        end
    end

    // Decode the strobes and the bus drive from the current phase.
    always_comb begin
        in_access = (phase == PH_ASET) || (phase == PH_DSET);
        in_data   = (phase == PH_DSET);
        mem_cs_n  = !in_access;
        mem_oe_n  = !(in_data && !we_q);
        mem_we_n  = !(in_data && we_q);
        mem_dq_oe = in_access && we_q;
    end

    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;

endmodule

// File: rtl/smem_async_ctrl.sv
// Top of the asynchronous static memory sequencer.
// Joins the phase sequencer, the shared phase timer and the pin stage.
// Assumes: a single memory device, and an I/O cell outside that joins the split data bus.
module smem_async_ctrl
    import smem_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16,
    parameter int ASU_W  = 4,
    parameter int DSU_W  = 8,
    parameter int TURN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [ASU_W-1:0]  cfg_addr_setup,
    input  logic [DSU_W-1:0]  cfg_data_setup,
    input  logic [TURN_W-1:0] cfg_turnaround,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int CNT_W = max3(ASU_W, DSU_W, TURN_W);

    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    logic             accept;
    logic             capture;
    smem_phase_e      phase;

    smem_sequencer #(
        .ASU_W  (ASU_W),
        .DSU_W  (DSU_W),
        .TURN_W (TURN_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .cfg_asu  (cfg_addr_setup),
        .cfg_dsu  (cfg_data_setup),
        .cfg_turn (cfg_turnaround),
        .expired  (expired),
        .load     (load),
        .load_val (load_val),
        .phase    (phase),
        .accept   (accept),
        .capture  (capture),
        .done     (done)
    );

    smem_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    smem_pin_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .accept    (accept),
        .capture   (capture),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_i  (mem_dq_i),
        .rd_data   (rd_data),
        .mem_cs_n  (mem_cs_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe)
    );

endmodule

// File: rtl/smem_async_chk.sv
// Protocol checker for the memory pins, bound to the top module.
// Assumes: synchronous active-low reset, with all properties held off during reset.
module smem_async_chk #(
    parameter int ADDR_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr
);

    // R10
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R10
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

    // R6
    dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_cs_n && mem_oe_n));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_cs_n && mem_oe_n && mem_we_n));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R3
    strobe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_oe_n) || $rose(mem_we_n)) |-> $rose(mem_cs_n));

endmodule

bind smem_async_ctrl smem_async_chk #(
    .ADDR_W (ADDR_W)
) u_smem_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr)
);

// File: tb/test_smem_async_ctrl.sv
`timescale 1ns/1ps
module test_smem_async_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [25:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  cfg_addr_setup = '0;
    logic [7:0]  cfg_data_setup = '0;
    logic [3:0]  cfg_turnaround = '0;
    logic [15:0] rd_data;
    logic        done;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [25:0] mem_addr;
    logic [15:0] mem_dq_o;
    logic [15:0] mem_dq_i;
    logic [15:0] oe_idx = '0;

    always #10 clk = ~clk;

    smem_async_ctrl i_smem_async_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req            (req),
        .req_we         (req_we),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .cfg_addr_setup (cfg_addr_setup),
        .cfg_data_setup (cfg_data_setup),
        .cfg_turnaround (cfg_turnaround),
        .rd_data        (rd_data),
        .done           (done),
        .mem_cs_n       (mem_cs_n),
        .mem_oe_n       (mem_oe_n),
        .mem_we_n       (mem_we_n),
        .mem_addr       (mem_addr),
        .mem_dq_o       (mem_dq_o),
        .mem_dq_oe      (mem_dq_oe),
        .mem_dq_i       (mem_dq_i)
    );

    // Memory model: the read word moves on by one for each cycle output enable stays low.
    always @(posedge clk) oe_idx <= mem_oe_n ? 16'd0 : oe_idx + 16'd1;
    assign mem_dq_i = mem_oe_n ? 16'h0000 : ((mem_addr[15:0] ^ 16'h5A5A) + oe_idx);

    typedef struct {
        logic        we;
        logic [25:0] addr;
        logic [15:0] data;
        int          asu;
        int          dsu;
        int          turn;
        bit          b2b;
    } item_t;

    item_t q[$];
    item_t cur;
    int total = 0, bad = 0, pushed = 0, starts = 0;
    int n_a, n_d, n_g;
    bit active = 0, bus_ok, addr_ok, kind_ok, prev_cs = 1, prev_done = 0, finished = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: follows each access on the pins and compares it with the queue head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n) begin
                if (prev_cs) begin
                    starts++;
                    if (q.size() == 0) begin
                        check(0, "R8 access without request", 1, 0);
                    end else begin
                        cur = q[0];
                        n_a = 0; n_d = 0; n_g = 0;
                        bus_ok = 1; addr_ok = 1; kind_ok = 1; active = 1;
                        if (cur.b2b) check(prev_done, "R8 held request not taken in done cycle", prev_done, 1);
                    end
                end
                if (active) begin
                    if (!mem_oe_n || !mem_we_n) n_d++; else n_a++;
                    if (cur.we ? !mem_oe_n : !mem_we_n) kind_ok = 0;
                    if (mem_dq_oe !== cur.we || (cur.we && mem_dq_o !== cur.data)) bus_ok = 0;
                    if (mem_addr !== cur.addr) addr_ok = 0;
                end
            end else begin
                if (mem_dq_oe) check(0, "R6 bus driven outside access", 1, 0);
                if (done && prev_done) check(0, "R4 done longer than one cycle", 2, 1);
                if (done) begin
                    if (!active) begin
                        check(0, "R4 done without access", 1, 0);
                    end else begin
                        check(n_a == cur.asu, "R2 address setup cycles", n_a, cur.asu);
                        check(n_d == cur.dsu + 1, "R3 data phase cycles", n_d, cur.dsu + 1);
                        check(kind_ok, "R3 strobe kind", kind_ok, 1);
                        check(n_g == cur.turn, "R4 turnaround cycles", n_g, cur.turn);
                        check(bus_ok, "R6 write bus drive", bus_ok, 1);
                        check(addr_ok, "R7 address held", addr_ok, 1);
                        if (!cur.we)
                            check(rd_data == ((cur.addr[15:0] ^ 16'h5A5A) + 16'(cur.dsu)),
                                  "R5 read capture", rd_data, (cur.addr[15:0] ^ 16'h5A5A) + 16'(cur.dsu));
                        void'(q.pop_front());
                        active = 0;
                    end
                end else if (active) begin
                    n_g++;
                end
            end
            prev_cs = mem_cs_n;
            prev_done = done;
        end
    end

    // Driver: queues the expected access, raises req and waits until the access starts.
    task automatic access(input logic we, input logic [25:0] addr, input logic [15:0] data,
                          input int asu, input int dsu, input int turn);
        item_t it;
        it.we = we; it.addr = addr; it.data = data;
        it.asu = asu; it.dsu = dsu; it.turn = turn;
        it.b2b = (q.size() != 0);
        req_we = we; req_addr = addr; req_wdata = data;
        cfg_addr_setup = 4'(asu); cfg_data_setup = 8'(dsu); cfg_turnaround = 4'(turn);
        req = 1'b1;
        q.push_back(it);
        pushed++;
        do begin
            @(posedge clk); #5;
        end while (starts < pushed);
        req = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        #5;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #5;
        // R1: outputs inside reset
        check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !done, "R1 in reset",
              {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, done}, 5'b11100);
        rst_n = 1'b1;
        @(posedge clk); #5;
        check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !done, "R1 after release",
              {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, done}, 5'b11100);

        access(0, 26'h0001234, 16'h0000, 3, 4, 2);     // plain read
        drain();
        access(1, 26'h3FFFFFF, 16'hBEEF, 0, 0, 0);     // R2 zero setup, shortest write
        drain();
        access(0, 26'h0000010, 16'h0000, 0, 0, 0);     // shortest read
        drain();
        access(1, 26'h2A5A5A5, 16'h1357, 15, 255, 15); // longest write
        drain();
        access(0, 26'h1000777, 16'h0000, 1, 255, 1);   // R5 capture at last of 256 cycles
        drain();
        // R8, R9: requests held through busy accesses with new values each time
        access(1, 26'h0000ABC, 16'hCAFE, 2, 1, 1);
        access(0, 26'h0000DEF, 16'h0000, 1, 2, 0);
        access(1, 26'h0000123, 16'h8001, 0, 3, 3);
        access(0, 26'h0000456, 16'h0000, 4, 0, 2);
        drain();
        // R8: a short request pulse while busy is ignored
        access(0, 26'h0000999, 16'h0000, 5, 6, 4);
        req_addr = 26'h3333333; req_we = 1'b1; cfg_addr_setup = 4'd0; req = 1'b1;
        @(posedge clk); #5;
        req = 1'b0;
        drain();
        repeat (10) @(posedge clk);
        check(starts == pushed, "R8 access count", starts, pushed);
        check(mem_cs_n && !mem_dq_oe && !done, "R4 idle after drain",
              {mem_cs_n, mem_dq_oe, done}, 3'b100);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule